// File: doc/BRIEF.md
# Interrupt and Transfer-Request Steering

This block sits between a bank of peripheral interrupt sources, a data-transfer engine and the CPU. Each source has a pending flag, a transfer-enable bit and a disable-select bit. A pending source with its enable bit set is routed to the transfer engine as an activation request, and its CPU interrupt is held back. A pending source with its enable bit clear is shown to the CPU as an interrupt.

When the transfer engine reports that a transfer has ended, it sends a pulse with the source index and a flag that says whether its transfer counter has reached zero. The block ORs that flag with the source's disable-select bit. If the result is 1, the enable bit is cleared and the flag is kept, so the CPU gets an interrupt. If the result is 0, the flag is cleared quietly and the enable bit stays set, so the next request goes to the engine again. Software writes the enable and disable-select bits through a small register port, and it clears flags by writing ones.

Top module: `irq_steer_top`

## Requirements
- R1: A source whose flag and transfer-enable bit are both 1 does not appear in `cpu_pend` and does not raise `cpu_irq`.
- R2: One cycle after the flag register shows at least one pending, enabled source while `act_req` is low, `act_req` rises and `act_idx` names the lowest-numbered such source. `act_req` and `act_idx` then hold until a `te_valid` pulse arrives whose `te_idx` equals `act_idx`. A pulse with any other index leaves them unchanged. `act_req` falls on the edge that takes the matching pulse.
- R3: On a matching transfer end where the disable-select bit or `te_cnt_zero` is 1, the source's enable bit becomes 0 and its flag stays 1, so `cpu_irq` rises on the next cycle.
- R4: On a transfer end where both the disable-select bit and `te_cnt_zero` are 0, the source's flag becomes 0 and its enable bit stays 1, and no CPU interrupt results.
- R5: With the disable-select bit set, each transfer end clears the enable bit even when `te_cnt_zero` is 0. Once software clears the flag and writes the enable bit back to 1, the next request is served again and ends the same way.
- R6: A one-cycle `flag_set` pulse sets the flag. A register write to address 2 clears each flag whose data bit is 1. When a set and a clear hit the same flag in the same cycle, the set wins.
- R7: `cpu_pend` is the bitwise AND of the flags with the inverted enable bits, and `cpu_irq` is 1 exactly when `cpu_pend` is non-zero.
- R8: When a register write to the enable bits and a hardware enable-clear from a transfer end fall in the same cycle, that source's enable bit ends at 0.
- R9: After reset, all flags, enable bits and disable-select bits are 0, and `act_req`, `cpu_irq` and `cpu_pend` are 0.
- R10: The register map is: address 0 holds the transfer-enable bits (read/write), address 1 holds the disable-select bits (read/write), and address 2 holds the flags (read, write-one-to-clear). Address 3 reads 0. `rd_data` is combinational from `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_set | input | N_SRC | One-cycle set pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | N_SRC | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | N_SRC | Register read data |
| te_valid | input | 1 | Transfer-end pulse from the engine |
| te_idx | input | IDX_W | Source index of the ended transfer |
| te_cnt_zero | input | 1 | Transfer counter reached zero |
| act_req | output | 1 | Transfer activation request |
| act_idx | output | IDX_W | Source index of the active request |
| cpu_irq | output | 1 | CPU interrupt request |
| cpu_pend | output | N_SRC | Sources currently asserting to the CPU |

## Verification
The bench builds the block with eight sources and a three-bit index. With these values it can reach both the lowest index (0) and the highest (7), and it can check lowest-first selection when sources 2 and 5 are pending together. The same settings let it drive a transfer-end pulse whose index does not match the active one. They also let it check both outcomes of the clear qualifier: once from the disable-select bit and once from the counter-zero input. The width also leaves room for a same-cycle enable write against a hardware clear.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
   typedef enum logic [1:0] {
      REG_XFER_EN = 2'd0,
      REG_DSEL    = 2'd1,
      REG_FLAG    = 2'd2,
      REG_NONE    = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irq_src_cell.sv
// Per-source state: pending flag, transfer-enable bit, disable-select bit.
module irq_src_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_pulse,
   input  logic sw_clr,
   input  logic en_wr,
   input  logic en_wdata,
   input  logic dsel_wr,
   input  logic dsel_wdata,
   input  logic te_hit,
   input  logic te_cnt_zero,
   output logic flag_q,
   output logic en_q,
   output logic dsel_q
);
   logic qual, hw_en_clr, hw_flag_clr;

   // Clear qualifier: disable-select ORed with counter exhaustion
   assign qual        = dsel_q | te_cnt_zero;
   assign hw_en_clr   = te_hit & qual;
   assign hw_flag_clr = te_hit & ~qual;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         en_q   <= 1'b0;
         dsel_q <= 1'b0;
      end else begin
         // set dominates any clear in the same cycle
         flag_q <= set_pulse | (flag_q & ~(sw_clr | hw_flag_clr));
         if (hw_en_clr)  en_q <= 1'b0;      // hardware clear beats a write
         else if (en_wr) en_q <= en_wdata;
         if (dsel_wr)    dsel_q <= dsel_wdata;
      end
   end

   AST_QUAL_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      te_hit && qual |=> !en_q); // R3
   AST_QUAL_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      te_hit && qual && flag_q && !sw_clr |=> flag_q); // R3
   AST_NOQUAL_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      te_hit && !qual && !set_pulse |=> !flag_q); // R4
   AST_NOQUAL_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      te_hit && !qual && en_q && !en_wr |=> en_q); // R4
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse |=> flag_q); // R6
   AST_HW_BEATS_WR: assert property (@(posedge clk) disable iff (!rst_n)
      te_hit && qual && en_wr && en_wdata |=> !en_q); // R8
endmodule

// File: rtl/irq_pick_lowest.sv
// Lowest-index priority pick over a request vector.
module irq_pick_lowest #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/irq_xfer_tracker.sv
// Holds the active activation request until its transfer-end pulse arrives.
module irq_xfer_tracker #(
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cand_any,
   input  logic [IW-1:0] cand_idx,
   input  logic          te_valid,
   input  logic [IW-1:0] te_idx,
   output logic          busy_q,
   output logic [IW-1:0] idx_q
);
   logic done;
   assign done = te_valid && (te_idx == idx_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (busy_q) begin
         if (done) busy_q <= 1'b0;
      end else if (cand_any) begin
         busy_q <= 1'b1;
         idx_q  <= cand_idx;
      end
   end

   AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !done |=> busy_q && $stable(idx_q)); // R2
   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && done |=> !busy_q); // R2
endmodule

// File: rtl/irq_steer_top.sv
module irq_steer_top
   import irq_steer_pkg::*;
#(
   parameter int N_SRC = 8,
   parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] flag_set,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [N_SRC-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [N_SRC-1:0] rd_data,
   input  logic             te_valid,
   input  logic [IDX_W-1:0] te_idx,
   input  logic             te_cnt_zero,
   output logic             act_req,
   output logic [IDX_W-1:0] act_idx,
   output logic             cpu_irq,
   output logic [N_SRC-1:0] cpu_pend
);
   localparam int MIN_IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   if (N_SRC < 2 || N_SRC > 32) begin : g_bad_count
      $error("irq_steer_top: N_SRC must lie in 2..32");
   end
   if (IDX_W < MIN_IW) begin : g_bad_width
      $error("irq_steer_top: IDX_W too narrow for N_SRC");
   end

   logic [N_SRC-1:0] flag_v, en_v, dsel_v, eligible;
   logic             wr_en_sel, wr_dsel_sel, wr_flag_sel;
   logic             cand_any;
   logic [IDX_W-1:0] cand_idx;

   assign wr_en_sel   = wr_en && (wr_addr == REG_XFER_EN);
   assign wr_dsel_sel = wr_en && (wr_addr == REG_DSEL);
   assign wr_flag_sel = wr_en && (wr_addr == REG_FLAG);

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      irq_src_cell u_cell (
         .clk         (clk),
         .rst_n       (rst_n),
         .set_pulse   (flag_set[i]),
         .sw_clr      (wr_flag_sel & wr_data[i]),
         .en_wr       (wr_en_sel),
         .en_wdata    (wr_data[i]),
         .dsel_wr     (wr_dsel_sel),
         .dsel_wdata  (wr_data[i]),
         .te_hit      (te_valid && (te_idx == IDX_W'(i))),
         .te_cnt_zero (te_cnt_zero),
         .flag_q      (flag_v[i]),
         .en_q        (en_v[i]),
         .dsel_q      (dsel_v[i])
      );
   end

   assign eligible = flag_v & en_v;
   assign cpu_pend = flag_v & ~en_v;
   assign cpu_irq  = |cpu_pend;

   irq_pick_lowest #(.N(N_SRC), .IW(IDX_W)) u_pick (
      .req (eligible),
      .any (cand_any),
      .idx (cand_idx)
   );

   irq_xfer_tracker #(.IW(IDX_W)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .cand_any (cand_any),
      .cand_idx (cand_idx),
      .te_valid (te_valid),
      .te_idx   (te_idx),
      .busy_q   (act_req),
      .idx_q    (act_idx)
   );

   always_comb begin
      case (reg_sel_e'(rd_addr))
         REG_XFER_EN: rd_data = en_v;
         REG_DSEL:    rd_data = dsel_v;
         REG_FLAG:    rd_data = flag_v;
         default:     rd_data = '0;
      endcase
   end

   AST_GRANT_PICK: assert property (@(posedge clk) disable iff (!rst_n)
      !act_req && cand_any |=> act_req && act_idx == $past(cand_idx)); // R2
   AST_ENABLED_NOT_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_v & en_v) & cpu_pend) == '0); // R1
endmodule

// File: tb/sim_irq_steer_top.sv
`timescale 1ns/1ps
module sim_irq_steer_top;
   localparam int N  = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  flag_set, wr_data, rd_data, cpu_pend;
   logic          wr_en, te_valid, te_cnt_zero, act_req, cpu_irq;
   logic [1:0]    wr_addr, rd_addr;
   logic [IW-1:0] te_idx, act_idx;

   always #2.5 clk = ~clk;

   irq_steer_top #(.N_SRC(N), .IDX_W(IW)) u0 (
      .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .te_valid(te_valid), .te_idx(te_idx),
      .te_cnt_zero(te_cnt_zero), .act_req(act_req), .act_idx(act_idx),
      .cpu_irq(cpu_irq), .cpu_pend(cpu_pend)
   );

   // selectors: 0 act_req, 1 act_idx, 2 cpu_irq, 3 cpu_pend, 4 rd_data
   typedef struct {
      string       req;
      int          sel;
      logic [1:0]  addr;
      logic [31:0] exp;
   } item_t;

   item_t q[$];
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;

   task automatic expect_item(input string r, input int sel,
                              input logic [1:0] a, input logic [31:0] e);
      item_t it;
      it.req = r; it.sel = sel; it.addr = a; it.exp = e;
      q.push_back(it);
   endtask

   // monitor: pops every queued item shortly after each falling edge
   initial begin
      rd_addr = 2'd0;
      forever begin
         @(negedge clk);
         #0.5;
         while (q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it = q.pop_front();
            if (it.sel == 4) begin
               rd_addr = it.addr;
               #0.1;
            end
            case (it.sel)
               0: got = 32'(act_req);
               1: got = 32'(act_idx);
               2: got = 32'(cpu_irq);
               3: got = 32'(cpu_pend);
               default: got = 32'(rd_data);
            endcase
            n_cmp++;
            if (got !== it.exp) begin
               n_bad++;
               $display("FAIL %s sel=%0d: got %0h expected %0h",
                        it.req, it.sel, got, it.exp);
            end
         end
      end
   end

   task automatic step();
      @(negedge clk);
      flag_set = '0; wr_en = 1'b0; te_valid = 1'b0; te_cnt_zero = 1'b0;
   endtask

   task automatic wreg(input logic [1:0] a, input logic [N-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
   endtask

   task automatic tend(input logic [IW-1:0] i, input logic cz);
      te_valid = 1'b1; te_idx = i; te_cnt_zero = cz;
      step();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; flag_set = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      te_valid = 1'b0; te_idx = '0; te_cnt_zero = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      // R9 reset state
      expect_item("R9", 0, 0, 0);
      expect_item("R9", 2, 0, 0);
      expect_item("R9", 3, 0, 0);
      expect_item("R9", 4, 2'd0, 0);
      expect_item("R9", 4, 2'd1, 0);
      expect_item("R9", 4, 2'd2, 0);

      // R6/R7: flag set with enable off goes to CPU
      flag_set = 8'h04; step();
      expect_item("R6", 4, 2'd2, 32'h04);
      expect_item("R7", 3, 0, 32'h04);
      expect_item("R7", 2, 0, 1);
      step();
      expect_item("R7", 0, 0, 0);
      wreg(2'd2, 8'h04);
      expect_item("R6", 3, 0, 0);
      expect_item("R7", 2, 0, 0);
      // R6 set and clear in same cycle: set wins
      flag_set = 8'h04; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h04; step();
      expect_item("R6", 4, 2'd2, 32'h04);
      wreg(2'd2, 8'h04);
      // R10 address 3 reads zero
      expect_item("R10", 4, 2'd3, 0);

      // R1/R2/R4: sources 2 and 5 routed to the transfer engine
      wreg(2'd0, 8'h24);
      expect_item("R10", 4, 2'd0, 32'h24);
      flag_set = 8'h24; step();
      expect_item("R1", 3, 0, 0);
      expect_item("R1", 2, 0, 0);
      expect_item("R2", 0, 0, 0);
      step();
      expect_item("R2", 0, 0, 1);
      expect_item("R2", 1, 0, 2);
      tend(3'd3, 1'b0);        // non-matching index
      expect_item("R2", 0, 0, 1);
      expect_item("R2", 1, 0, 2);
      tend(3'd2, 1'b0);        // qualifier 0
      expect_item("R4", 0, 0, 0);
      expect_item("R4", 4, 2'd2, 32'h20);
      expect_item("R4", 4, 2'd0, 32'h24);
      expect_item("R4", 2, 0, 0);
      step();
      expect_item("R2", 0, 0, 1);
      expect_item("R2", 1, 0, 5);
      tend(3'd5, 1'b1);        // counter zero -> hand to CPU
      expect_item("R3", 4, 2'd0, 32'h04);
      expect_item("R3", 4, 2'd2, 32'h20);
      expect_item("R3", 3, 0, 32'h20);
      expect_item("R3", 2, 0, 1);
      step();
      expect_item("R3", 0, 0, 0);
      wreg(2'd2, 8'h20);
      expect_item("R7", 2, 0, 0);
      wreg(2'd0, 8'h00);

      // R5: disable-select on source 7, two transfers
      wreg(2'd1, 8'h80);
      expect_item("R10", 4, 2'd1, 32'h80);
      wreg(2'd0, 8'h80);
      for (int k = 0; k < 2; k++) begin
         flag_set = 8'h80; step();
         step();
         expect_item("R5", 0, 0, 1);
         expect_item("R5", 1, 0, 7);
         tend(3'd7, 1'b0);
         expect_item("R5", 4, 2'd0, 0);
         expect_item("R5", 3, 0, 32'h80);
         expect_item("R5", 2, 0, 1);
         wreg(2'd2, 8'h80);
         wreg(2'd0, 8'h80);
         expect_item("R5", 2, 0, 0);
      end
      wreg(2'd0, 8'h00);
      wreg(2'd1, 8'h00);

      // R8: enable write against hardware clear on source 0
      wreg(2'd0, 8'h01);
      flag_set = 8'h01; step();
      step();
      expect_item("R8", 1, 0, 0);
      te_valid = 1'b1; te_idx = 3'd0; te_cnt_zero = 1'b1;
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h01;
      step();
      expect_item("R8", 4, 2'd0, 0);
      expect_item("R8", 3, 0, 32'h01);
      step();
      step();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule